// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Controller

This block arbitrates interrupt requests from six internal sources: transmit, receive and external/status events for two channels. Each source has an enable flag, a pending flag and an under-service flag. An event on a source raises its pending flag only while that source is enabled. The block raises an active-low request toward the processor when some pending source is not masked by a higher or equal source already under service, and the chain input says that no upstream device has claimed priority.

An acknowledge comes either from a hardware strobe or from a software command, and both have the same effect. The acknowledge promotes the winning source from pending to under service and returns its 3-bit code on the following cycle. While anything is pending or under service, the chain output is held low so that downstream devices stay silent. Service ends in one of two ways: a command that retires only the highest-priority source under service, which allows nesting, or per-source clear bits. Simple strobes take the place of the bus decoder and the register file.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: A synchronous reset clears every enable, pending and under-service flag, drives `int_n` high and `ack_valid` low.
- R2: An event on a source whose enable flag is 0 is ignored: its pending flag stays 0.
- R3: An event on an enabled source sets its pending flag, visible on `pend_rd` one cycle after the event edge; `pend_rd` bit i is the pending flag of source i.
- R4: `int_n` is registered and goes low at the edge where `iei` is high and some source i is pending with no under-service flag at index 0..i.
- R5: Source codes and priority, highest first: 0 = channel A transmit, 1 = A receive, 2 = A external/status, 3 = B transmit, 4 = B receive, 5 = B external/status; an acknowledge picks the lowest requesting code.
- R6: An acknowledge while `iei` is low changes nothing and leaves `ack_valid` low.
- R7: An acknowledge with `iei` high and a requesting source sets that source's under-service flag, clears its pending flag, and pulses `ack_valid` with `ack_id` equal to its code one cycle later.
- R8: While any under-service flag is set, `ieo` is low and every source with a higher code is kept from requesting.
- R9: `ieo` follows `iei` when nothing is pending or under service, and is low otherwise.
- R10: The software acknowledge `ack_sw` has exactly the effect of the hardware strobe `ack_hw`.
- R11: `eoi_hi` clears only the lowest-coded (highest-priority) under-service flag, so a lower source still in service keeps blocking.
- R12: `eos_mask` bit i clears the under-service flag of source i.
- R13: An enable write (`en_we`) loads all six enable flags from `en_d`; an event in the same cycle uses the old enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_we | input | 1 | Load strobe for the enable flags |
| en_d | input | 6 | New enable flags, bit i for source i |
| evt | input | 6 | Event pulses, bit i for source i |
| iei | input | 1 | Chain enable from the upstream device |
| ack_hw | input | 1 | Hardware acknowledge strobe |
| ack_sw | input | 1 | Software acknowledge command |
| eoi_hi | input | 1 | Retire the highest-priority source under service |
| eos_mask | input | 6 | Per-source end-of-service clears |
| int_n | output | 1 | Active-low interrupt request, registered |
| ieo | output | 1 | Chain enable to the downstream device |
| pend_rd | output | 6 | Pending flags read back as one value |
| ack_valid | output | 1 | One-cycle flag: `ack_id` holds a serviced code |
| ack_id | output | 3 | Code of the source taken by the last acknowledge |

## Verification
Every flag, `int_n`, `ack_valid` and `ack_id` changes on the clock edge that samples the stimulus. The bench therefore drives each input on a falling edge, advances the reference model at the next rising edge, and compares one time unit later. `ieo` is the only combinational output and is compared at that same instant against the current `iei`. Directed sequences place nested acknowledges, end-of-service commands and disabled events so that each result falls on a known edge. Random traffic is checked against the model on every cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int SRC_PER_CH = 3;
  typedef enum logic [1:0] {SRC_TX = 2'd0, SRC_RX = 2'd1, SRC_EXT = 2'd2} src_kind_e;
endpackage

// File: rtl/irq_prio_pick.sv
// Isolates the lowest set bit (highest priority) of a request vector.
module irq_prio_pick #(
  parameter int W = 6
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] oh
);
  assign oh = vec & (~vec + W'(1));
endmodule

// File: rtl/irq_src_cell.sv
// Enable, pending and under-service state of one interrupt source.
module irq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic en_we,
  input  logic en_d,
  input  logic evt,
  input  logic take,
  input  logic clr,
  output logic en_q,
  output logic pend_q,
  output logic ius_q,
  output logic pend_n,
  output logic ius_n
);
  // Events are gated by the enable held before any same-cycle write.
  assign pend_n = (pend_q | (evt & en_q)) & ~take;
  assign ius_n  = (ius_q & ~clr) | take;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      ius_q  <= 1'b0;
    end else begin
      if (en_we) en_q <= en_d;
      pend_q <= pend_n;
      ius_q  <= ius_n;
    end
  end
endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_CH = 2,
  localparam int NSRC = N_CH * SRC_PER_CH,
  localparam int ID_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_d,
  input  logic [NSRC-1:0] evt,
  input  logic            iei,
  input  logic            ack_hw,
  input  logic            ack_sw,
  input  logic            eoi_hi,
  input  logic [NSRC-1:0] eos_mask,
  output logic            int_n,
  output logic            ieo,
  output logic [NSRC-1:0] pend_rd,
  output logic            ack_valid,
  output logic [ID_W-1:0] ack_id
);
  logic [NSRC-1:0] en_q, pend_q, ius_q, pend_n, ius_n;
  logic [NSRC-1:0] blk, req, blk_n, req_n;
  logic [NSRC-1:0] win_oh, hi_oh, take, clr;
  logic [ID_W-1:0] win_idx;
  logic            ack_go;

  // Under-service masks: bit i is blocked by any under-service flag at 0..i.
  assign blk[0]   = ius_q[0];
  assign blk_n[0] = ius_n[0];
  for (genvar i = 1; i < NSRC; i++) begin : g_mask
    assign blk[i]   = blk[i-1] | ius_q[i];
    assign blk_n[i] = blk_n[i-1] | ius_n[i];
  end

  assign req   = pend_q & ~blk;
  assign req_n = pend_n & ~blk_n;

  irq_prio_pick #(.W(NSRC)) u_win (.vec(req),   .oh(win_oh));
  irq_prio_pick #(.W(NSRC)) u_hi  (.vec(ius_q), .oh(hi_oh));

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (win_oh[i]) win_idx = ID_W'(i);
  end

  assign ack_go = (ack_hw | ack_sw) & iei & (|req);
  assign take   = ack_go ? win_oh : '0;
  assign clr    = eos_mask | (eoi_hi ? hi_oh : '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .en_we  (en_we),
      .en_d   (en_d[i]),
      .evt    (evt[i]),
      .take   (take[i]),
      .clr    (clr[i]),
      .en_q   (en_q[i]),
      .pend_q (pend_q[i]),
      .ius_q  (ius_q[i]),
      .pend_n (pend_n[i]),
      .ius_n  (ius_n[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_n     <= 1'b1;
      ack_valid <= 1'b0;
      ack_id    <= '0;
    end else begin
      int_n     <= ~(iei & (|req_n));
      ack_valid <= ack_go;
      if (ack_go) ack_id <= win_idx;
    end
  end

  assign ieo     = iei & ~(|pend_q) & ~(|ius_q);
  assign pend_rd = pend_q;
endmodule

// File: rtl/irq_daisy_ctrl_chk.sv
module irq_daisy_ctrl_chk #(
  parameter int NSRC = 6,
  parameter int ID_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] evt,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] ius_q,
  input logic            iei,
  input logic            ack_hw,
  input logic            ack_sw,
  input logic            int_n,
  input logic            ieo,
  input logic [NSRC-1:0] pend_rd,
  input logic            ack_valid,
  input logic [ID_W-1:0] ack_id
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (int_n && !ack_valid && pend_rd == '0 && ius_q == '0));

  a_r2_gated_set: assert property (@(posedge clk) disable iff (rst)
    ((pend_rd & ~$past(pend_rd)) & ~$past(evt & en_q)) == '0);

  a_r4_req_needs_iei: assert property (@(posedge clk) disable iff (rst)
    !int_n |-> $past(iei));

  a_r6_no_ack_chain_low: assert property (@(posedge clk) disable iff (rst)
    ((ack_hw || ack_sw) && !iei) |=> !ack_valid);

  a_r7_ack_cause: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> ($past(ack_hw || ack_sw) && $past(iei)));

  a_r7_promoted: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> (ius_q[ack_id] && !pend_rd[ack_id]));

  a_r8_ieo_blocked: assert property (@(posedge clk) disable iff (rst)
    (|ius_q) |-> !ieo);

  a_r9_ieo_pass: assert property (@(posedge clk) disable iff (rst)
    (ius_q == '0 && pend_rd == '0) |-> (ieo == iei));
endmodule

bind irq_daisy_ctrl irq_daisy_ctrl_chk #(.NSRC(NSRC), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt       (evt),
  .en_q      (en_q),
  .ius_q     (ius_q),
  .iei       (iei),
  .ack_hw    (ack_hw),
  .ack_sw    (ack_sw),
  .int_n     (int_n),
  .ieo       (ieo),
  .pend_rd   (pend_rd),
  .ack_valid (ack_valid),
  .ack_id    (ack_id)
);

// File: tb/irq_daisy_ctrl_tb.sv
module irq_daisy_ctrl_tb;
  localparam int N = 6;

  logic clk = 1'b0;
  logic rst, en_we, iei, ack_hw, ack_sw, eoi_hi;
  logic [N-1:0] en_d, evt, eos_mask;
  logic int_n, ieo, ack_valid;
  logic [N-1:0] pend_rd;
  logic [2:0] ack_id;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [N-1:0] en_m, pend_m, ius_m;
  logic int_n_m, ack_valid_m;
  logic [2:0] ack_id_m;

  always #2 clk = ~clk;

  irq_daisy_ctrl u_dut (
    .clk(clk), .rst(rst), .en_we(en_we), .en_d(en_d), .evt(evt), .iei(iei),
    .ack_hw(ack_hw), .ack_sw(ack_sw), .eoi_hi(eoi_hi), .eos_mask(eos_mask),
    .int_n(int_n), .ieo(ieo), .pend_rd(pend_rd), .ack_valid(ack_valid), .ack_id(ack_id)
  );

  function automatic logic [N-1:0] lowbit(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic logic [N-1:0] upmask(input logic [N-1:0] u);
    logic [N-1:0] m;
    m[0] = u[0];
    for (int i = 1; i < N; i++) m[i] = m[i-1] | u[i];
    return m;
  endfunction

  function automatic logic [2:0] code_of(input logic [N-1:0] oh);
    for (int i = 0; i < N; i++) if (oh[i]) return 3'(i);
    return 3'd0;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    en_we = 0; en_d = '0; evt = '0; ack_hw = 0; ack_sw = 0; eoi_hi = 0; eos_mask = '0;
  endtask

  // Advance one clock: predict, clock, compare, return at the falling edge.
  task automatic step();
    logic [N-1:0] req_m, w, take_m, clr_m, pn, in_n;
    logic go;
    req_m  = pend_m & ~upmask(ius_m);
    w      = lowbit(req_m);
    go     = (ack_hw | ack_sw) & iei & (req_m != '0);
    take_m = go ? w : '0;
    clr_m  = eos_mask | (eoi_hi ? lowbit(ius_m) : '0);
    pn     = (pend_m | (evt & en_m)) & ~take_m;
    in_n   = (ius_m & ~clr_m) | take_m;
    @(posedge clk);
    if (rst) begin
      en_m = '0; pend_m = '0; ius_m = '0; int_n_m = 1; ack_valid_m = 0; ack_id_m = '0;
    end else begin
      if (en_we) en_m = en_d;
      pend_m = pn; ius_m = in_n;
      int_n_m = ~(iei & ((pn & ~upmask(in_n)) != '0));
      ack_valid_m = go;
      if (go) ack_id_m = code_of(w);
    end
    #1;
    chk("R3", "pend_rd", 8'(pend_rd), 8'(pend_m));
    chk("R4", "int_n", 8'(int_n), 8'(int_n_m));
    chk("R9", "ieo", 8'(ieo), 8'(iei & (pend_m == '0) & (ius_m == '0)));
    chk("R7", "ack_valid", 8'(ack_valid), 8'(ack_valid_m));
    if (ack_valid_m) chk("R5", "ack_id", 8'(ack_id), 8'(ack_id_m));
    @(negedge clk);
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    idle(); iei = 1; rst = 1;
    @(negedge clk);
    step(); step();
    chk("R1", "int_n after reset", 8'(int_n), 8'd1);
    chk("R1", "pend_rd after reset", 8'(pend_rd), 8'd0);
    chk("R1", "ack_valid after reset", 8'(ack_valid), 8'd0);
    rst = 0;

    // R2: events with all enables clear are ignored
    evt = 6'h3F; step(); idle();
    chk("R2", "pend after disabled evt", 8'(pend_rd), 8'd0);
    chk("R2", "int_n after disabled evt", 8'(int_n), 8'd1);

    // R13: enable write and event in the same cycle: old enables apply
    en_we = 1; en_d = 6'h3F; evt = 6'h01; step(); idle();
    chk("R13", "same-cycle evt uses old enable", 8'(pend_rd), 8'd0);

    // R3/R5: B ext and A ext pending; A ext wins
    evt = 6'b100100; step(); idle();
    chk("R3", "pend set", 8'(pend_rd), 8'h24);
    chk("R4", "int_n low", 8'(int_n), 8'd0);
    chk("R9", "ieo low while pending", 8'(ieo), 8'd0);

    // R6: acknowledge with iei low does nothing
    iei = 0; ack_hw = 1; step(); idle();
    chk("R6", "ack_valid with iei low", 8'(ack_valid), 8'd0);
    chk("R6", "pend kept", 8'(pend_rd), 8'h24);
    iei = 1; step();

    // R7/R5: hardware acknowledge takes code 2
    ack_hw = 1; step(); idle();
    chk("R7", "ack_valid", 8'(ack_valid), 8'd1);
    chk("R5", "ack_id A ext", 8'(ack_id), 8'd2);
    chk("R7", "pend cleared", 8'(pend_rd), 8'h20);
    chk("R8", "lower source blocked", 8'(int_n), 8'd1);
    chk("R8", "ieo low under service", 8'(ieo), 8'd0);

    // R12: per-source clear releases source 5
    eos_mask = 6'h04; step(); idle();
    chk("R12", "lower request after clear", 8'(int_n), 8'd0);
    // R10: software acknowledge takes code 5
    ack_sw = 1; step(); idle();
    chk("R10", "sw ack valid", 8'(ack_valid), 8'd1);
    chk("R10", "sw ack id", 8'(ack_id), 8'd5);

    // R11: nesting. Source 1 interrupts source 5 in service.
    evt = 6'h02; step(); idle();
    chk("R8", "higher source not blocked", 8'(int_n), 8'd0);
    ack_hw = 1; step(); idle();
    chk("R11", "nested ack id", 8'(ack_id), 8'd1);
    evt = 6'h04; step(); idle();
    chk("R8", "code 2 blocked by code 1", 8'(int_n), 8'd1);
    eoi_hi = 1; step(); idle();
    chk("R11", "code 2 released after eoi_hi", 8'(int_n), 8'd0);
    chk("R11", "code 5 still in service", 8'(ieo), 8'd0);
    ack_hw = 1; step(); idle();
    chk("R11", "ack code 2", 8'(ack_id), 8'd2);
    eos_mask = 6'h24; step(); idle();
    chk("R12", "all clear, ieo follows iei", 8'(ieo), 8'd1);

    // Random traffic checked against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      idle();
      if (($urandom % 4) == 0) evt = N'($urandom);
      if (($urandom % 6) == 0) begin
        if ($urandom % 2) ack_hw = 1; else ack_sw = 1;
      end
      iei = (($urandom % 8) != 0);
      if (($urandom % 10) == 0) eoi_hi = 1;
      if (($urandom % 25) == 0) eos_mask = N'($urandom);
      if (($urandom % 40) == 0) begin en_we = 1; en_d = N'($urandom); end
      if (c == 3000) rst = 1;
      step();
      rst = 0;
    end
    idle(); step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule